// File: doc/BRIEF.md
# Ethernet Channel Mode and Carrier-Sense Control

This block is the per-channel control logic of a 10/100 Ethernet transceiver. It settles the channel's operating speed and duplex. When auto-negotiation is on, it takes both from the auto-negotiation results. When auto-negotiation is off, it takes them from the control-register bits and the configuration pins. From the settled mode it builds the internal carrier-sense output, which is the receive carrier combined with a gated loopback of transmit enable. It also builds the collision output.

In 10 Mbps operation the block follows the receive polarity reported for each start-of-idle pulse. It inverts the received data while the polarity is reversed, unless automatic polarity correction has been turned off. It also drives registered status bits and two active-low LED outputs. The analog line interface, the auto-negotiation algorithm and the management framing are outside the block.

Top module: `phy_mode_ctrl`

## Requirements
- R1: With `an_enable`=0, the channel is full duplex when `reg_duplex` or `pin_duplex` is 1, and half duplex otherwise. `stat_full_duplex` shows this one clock after the inputs change.
- R2: With `an_enable`=0, the channel runs at 100 Mbps only when `reg_speed100` and `pin_speed100` are both 1, and at 10 Mbps otherwise. `stat_speed100` shows this one clock later.
- R3: With `an_enable`=1, speed and duplex follow `an_speed100` and `an_full_duplex`, and the forced bits and pins have no effect on the status outputs.
- R4: `crs` is `rx_carrier` ORed with `tx_en`, in the same cycle and with no register delay. The `tx_en` term is removed while any of these hold: `collision_in`, full duplex, `link_fail`, `rmii_mode`.
- R5: At 10 Mbps, `jabber` also removes the `tx_en` term from `crs`. At 100 Mbps, `jabber` has no effect on `crs`.
- R6: `col_out` follows `collision_in` in half duplex and is held at 0 in full duplex.
- R7: At 10 Mbps, a cycle with `soi_valid`=1 sets `stat_rev_pol` on the next clock to the value of `soi_inverted`. A single inverted pulse is enough to set it, and a later pulse of correct polarity clears it.
- R8: At 10 Mbps with `autopol_dis`=0 and `stat_rev_pol`=1, `rx_data_out` is the bitwise inverse of `rx_data_in`, in the same cycle. In every other case `rx_data_out` equals `rx_data_in`.
- R9: At 100 Mbps, start-of-idle pulses leave `stat_rev_pol` unchanged, and no data inversion is applied.
- R10: `rst` clears `stat_rev_pol`. A cycle with `link_fail`=1 also clears it, on the next clock.
- R11: `led1_n` is 0 exactly when the registered duplex is full, that is, it equals the inverse of `stat_full_duplex`.
- R12: `led0_n` is registered, one clock after its source. It is active low and shows the event selected by `led_sel`:
  - 0: 100 Mbps speed
  - 1: link up (`link_fail`=0)
  - 2: `crs`
  - 3: `col_out`
- R13: After reset, `stat_speed100`, `stat_full_duplex` and `stat_rev_pol` are 0, and `led0_n` and `led1_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| an_enable | input | 1 | Auto-negotiation enabled |
| reg_duplex | input | 1 | Control-register duplex bit (1 = full) |
| pin_duplex | input | 1 | Duplex configuration pin (1 = full) |
| reg_speed100 | input | 1 | Control-register speed bit (1 = 100 Mbps) |
| pin_speed100 | input | 1 | Speed configuration pin (1 = 100 Mbps) |
| an_speed100 | input | 1 | Speed resolved by auto-negotiation |
| an_full_duplex | input | 1 | Duplex resolved by auto-negotiation |
| led_sel | input | 2 | LED0 event select |
| tx_en | input | 1 | Transmit enable |
| rx_carrier | input | 1 | Receive carrier detect |
| collision_in | input | 1 | Raw collision detect |
| link_fail | input | 1 | Link-fail state |
| jabber | input | 1 | Jabber detected |
| rmii_mode | input | 1 | Reduced MII mode active |
| autopol_dis | input | 1 | Disable automatic polarity correction |
| soi_valid | input | 1 | Start-of-idle pulse seen this cycle |
| soi_inverted | input | 1 | That pulse showed inverted polarity |
| rx_data_in | input | DW | Received data before correction |
| rx_data_out | output | DW | Received data after polarity correction |
| crs | output | 1 | Carrier sense |
| col_out | output | 1 | Collision output |
| stat_speed100 | output | 1 | Status: 100 Mbps |
| stat_full_duplex | output | 1 | Status: full duplex |
| stat_rev_pol | output | 1 | Status: reverse polarity detected |
| led0_n | output | 1 | Selectable event LED, active low |
| led1_n | output | 1 | Full-duplex LED, active low |

## Verification
The assertions assume that `soi_valid` is only meaningful while the link is up. They also assume that the auto-negotiation results are stable whenever `an_enable` is 1, so the registered status and the combinational mode never disagree for more than one clock. The stimulus changes inputs only away from the clock edge. It holds each mode for at least one full cycle before checking the registered outputs, and it raises `link_fail` only as a deliberate test of the clearing rule.

// File: rtl/phy_mode_pkg.sv
package phy_mode_pkg;

    typedef struct packed {
        logic speed100;
        logic full_dup;
    } chan_mode_t;

    typedef enum logic [1:0] {
        LED0_SPEED = 2'd0,
        LED0_LINK  = 2'd1,
        LED0_CRS   = 2'd2,
        LED0_COL   = 2'd3
    } led0_evt_e;

    function automatic logic led0_event(input led0_evt_e sel, input logic spd,
                                        input logic link_ok, input logic cs,
                                        input logic col);
        case (sel)
            LED0_SPEED: return spd;
            LED0_LINK:  return link_ok;
            LED0_CRS:   return cs;
            default:    return col;
        endcase
    endfunction

endpackage

// File: rtl/mode_resolve.sv
module mode_resolve
    import phy_mode_pkg::*;
(
    input  logic       an_enable,
    input  logic       reg_duplex,
    input  logic       pin_duplex,
    input  logic       reg_speed100,
    input  logic       pin_speed100,
    input  logic       an_speed100,
    input  logic       an_full_duplex,
    output chan_mode_t mode
);
    chan_mode_t forced;

    always_comb begin
        // forced 100 Mbps needs bit and pin to agree
        forced.speed100 = reg_speed100 & pin_speed100;
        forced.full_dup = reg_duplex | pin_duplex;
        if (an_enable) begin
            mode.speed100 = an_speed100;
            mode.full_dup = an_full_duplex;
        end else begin
            mode = forced;
        end
    end
endmodule

// File: rtl/crs_gen.sv
module crs_gen
    import phy_mode_pkg::*;
(
    input  chan_mode_t mode,
    input  logic       tx_en,
    input  logic       rx_carrier,
    input  logic       collision_in,
    input  logic       link_fail,
    input  logic       jabber,
    input  logic       rmii_mode,
    output logic       crs,
    output logic       col_out
);
    logic loop_block;
    logic loop_term;

    always_comb begin
        loop_block = collision_in | mode.full_dup | link_fail | rmii_mode
                   | (jabber & ~mode.speed100);
        loop_term  = tx_en & ~loop_block;
        crs        = rx_carrier | loop_term;
        col_out    = collision_in & ~mode.full_dup;
    end
endmodule

// File: rtl/pol_track.sv
module pol_track
    import phy_mode_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  chan_mode_t    mode,
    input  logic          link_fail,
    input  logic          soi_valid,
    input  logic          soi_inverted,
    input  logic          autopol_dis,
    input  logic [DW-1:0] rx_data_in,
    output logic [DW-1:0] rx_data_out,
    output logic          rev_pol
);
    logic do_fix;

    always_ff @(posedge clk) begin
        if (rst || link_fail)
            rev_pol <= 1'b0;
        else if (soi_valid && !mode.speed100)
            rev_pol <= soi_inverted;
    end

    always_comb begin
        do_fix      = rev_pol & ~autopol_dis & ~mode.speed100;
        rx_data_out = rx_data_in ^ {DW{do_fix}};
    end

    // R10
    rev_clear_chk: assert property (@(posedge clk) disable iff (rst)
        link_fail |=> !rev_pol);

    // R9
    rev_hold_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.speed100 && !link_fail) |=> $stable(rev_pol));
endmodule

// File: rtl/led_status.sv
module led_status
    import phy_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chan_mode_t mode,
    input  logic [1:0] led_sel,
    input  logic       link_fail,
    input  logic       crs,
    input  logic       col_out,
    output logic       stat_speed100,
    output logic       stat_full_duplex,
    output logic       led0_n,
    output logic       led1_n
);
    logic led0_on;

    always_comb
        led0_on = led0_event(led0_evt_e'(led_sel), mode.speed100, ~link_fail, crs, col_out);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_speed100    <= 1'b0;
            stat_full_duplex <= 1'b0;
            led0_n           <= 1'b1;
            led1_n           <= 1'b1;
        end else begin
            stat_speed100    <= mode.speed100;
            stat_full_duplex <= mode.full_dup;
            led0_n           <= ~led0_on;
            led1_n           <= ~mode.full_dup;
        end
    end
endmodule

// File: rtl/phy_mode_ctrl.sv
module phy_mode_ctrl
    import phy_mode_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          an_enable,
    input  logic          reg_duplex,
    input  logic          pin_duplex,
    input  logic          reg_speed100,
    input  logic          pin_speed100,
    input  logic          an_speed100,
    input  logic          an_full_duplex,
    input  logic [1:0]    led_sel,
    input  logic          tx_en,
    input  logic          rx_carrier,
    input  logic          collision_in,
    input  logic          link_fail,
    input  logic          jabber,
    input  logic          rmii_mode,
    input  logic          autopol_dis,
    input  logic          soi_valid,
    input  logic          soi_inverted,
    input  logic [DW-1:0] rx_data_in,
    output logic [DW-1:0] rx_data_out,
    output logic          crs,
    output logic          col_out,
    output logic          stat_speed100,
    output logic          stat_full_duplex,
    output logic          stat_rev_pol,
    output logic          led0_n,
    output logic          led1_n
);
    chan_mode_t mode;

    mode_resolve u_mode (
        .an_enable      (an_enable),
        .reg_duplex     (reg_duplex),
        .pin_duplex     (pin_duplex),
        .reg_speed100   (reg_speed100),
        .pin_speed100   (pin_speed100),
        .an_speed100    (an_speed100),
        .an_full_duplex (an_full_duplex),
        .mode           (mode)
    );

    crs_gen u_crs (
        .mode         (mode),
        .tx_en        (tx_en),
        .rx_carrier   (rx_carrier),
        .collision_in (collision_in),
        .link_fail    (link_fail),
        .jabber       (jabber),
        .rmii_mode    (rmii_mode),
        .crs          (crs),
        .col_out      (col_out)
    );

    pol_track #(.DW(DW)) u_pol (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .link_fail    (link_fail),
        .soi_valid    (soi_valid),
        .soi_inverted (soi_inverted),
        .autopol_dis  (autopol_dis),
        .rx_data_in   (rx_data_in),
        .rx_data_out  (rx_data_out),
        .rev_pol      (stat_rev_pol)
    );

    led_status u_led (
        .clk              (clk),
        .rst              (rst),
        .mode             (mode),
        .led_sel          (led_sel),
        .link_fail        (link_fail),
        .crs              (crs),
        .col_out          (col_out),
        .stat_speed100    (stat_speed100),
        .stat_full_duplex (stat_full_duplex),
        .led0_n           (led0_n),
        .led1_n           (led1_n)
    );

    // R4
    crs_fdx_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.full_dup && !rx_carrier) |-> !crs);

    // R6
    col_fdx_chk: assert property (@(posedge clk) disable iff (rst)
        mode.full_dup |-> !col_out);

    // R11
    led1_match_chk: assert property (@(posedge clk) disable iff (rst)
        led1_n == !stat_full_duplex);

    // R4
    crs_carrier_chk: assert property (@(posedge clk) disable iff (rst)
        rx_carrier |-> crs);
endmodule

// File: tb/tb_phy_mode_ctrl.sv
module tb_phy_mode_ctrl;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst;
    logic an_enable, reg_duplex, pin_duplex, reg_speed100, pin_speed100;
    logic an_speed100, an_full_duplex;
    logic [1:0] led_sel;
    logic tx_en, rx_carrier, collision_in, link_fail, jabber, rmii_mode;
    logic autopol_dis, soi_valid, soi_inverted;
    logic [DW-1:0] rx_data_in, rx_data_out;
    logic crs, col_out, stat_speed100, stat_full_duplex, stat_rev_pol, led0_n, led1_n;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    phy_mode_ctrl #(.DW(DW)) dut (.*);

    // [8]an [7]reg_dup [6]pin_dup [5]reg_spd [4]pin_spd [3]an_spd [2]an_dup [1]exp_spd [0]exp_dup
    localparam logic [8:0] VEC [9] = '{
        9'b0_0000_00_00,
        9'b0_1000_00_01,
        9'b0_0100_00_01,
        9'b0_0011_00_10,
        9'b0_0010_00_00,
        9'b0_0001_00_00,
        9'b1_1111_00_00,
        9'b1_0000_11_11,
        9'b1_1010_10_10
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic an, input logic rd, input logic pd,
                            input logic rs, input logic ps, input logic as, input logic ad);
        an_enable = an; reg_duplex = rd; pin_duplex = pd;
        reg_speed100 = rs; pin_speed100 = ps; an_speed100 = as; an_full_duplex = ad;
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        set_mode(0, 0, 0, 0, 0, 0, 0);
        led_sel = 2'd0; tx_en = 0; rx_carrier = 0; collision_in = 0; link_fail = 0;
        jabber = 0; rmii_mode = 0; autopol_dis = 0; soi_valid = 0; soi_inverted = 0;
        rx_data_in = 8'h5A;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 speed", stat_speed100, 0);
        chk("R13 duplex", stat_full_duplex, 0);
        chk("R13 revpol", stat_rev_pol, 0);
        chk("R13 led0", led0_n, 1);
        chk("R13 led1", led1_n, 1);
        rst = 1'b0;

        // R1 R2 R3 mode table
        for (int i = 0; i < 9; i++) begin
            set_mode(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
            @(negedge clk);
            chk("R1/R2/R3 speed", stat_speed100, VEC[i][1]);
            chk("R1/R2/R3 duplex", stat_full_duplex, VEC[i][0]);
            chk("R11 led1", led1_n, !VEC[i][0]);
        end

        // 10 Mbps half duplex loopback
        set_mode(0, 0, 0, 0, 0, 0, 0);
        tx_en = 1; #1;
        chk("R4 loopback", crs, 1);
        collision_in = 1; #1;
        chk("R4 collision gate", crs, 0);
        chk("R6 col half", col_out, 1);
        rx_carrier = 1; #1;
        chk("R4 carrier pass", crs, 1);
        rx_carrier = 0; collision_in = 0;
        rmii_mode = 1; #1;
        chk("R4 rmii gate", crs, 0);
        rmii_mode = 0; link_fail = 1; #1;
        chk("R4 linkfail gate", crs, 0);
        link_fail = 0; jabber = 1; #1;
        chk("R5 jabber 10M", crs, 0);
        set_mode(0, 0, 0, 1, 1, 0, 0); #1;
        chk("R5 jabber 100M", crs, 1);
        jabber = 0;
        // full duplex
        set_mode(0, 0, 1, 0, 0, 0, 0); collision_in = 1; #1;
        chk("R4 fdx gate", crs, 0);
        chk("R6 col fdx", col_out, 0);
        collision_in = 0; tx_en = 0;
        @(negedge clk);

        // polarity at 10M
        set_mode(0, 0, 0, 0, 0, 0, 0);
        soi_valid = 1; soi_inverted = 1;
        @(negedge clk);
        soi_valid = 0; soi_inverted = 0; #1;
        chk("R7 set", stat_rev_pol, 1);
        chk("R8 invert", rx_data_out, 8'hA5);
        autopol_dis = 1; #1;
        chk("R8 autopol off", rx_data_out, 8'h5A);
        chk("R7 flag kept", stat_rev_pol, 1);
        autopol_dis = 0;
        soi_valid = 1;
        @(negedge clk);
        soi_valid = 0; #1;
        chk("R7 clear by good pulse", stat_rev_pol, 0);
        chk("R8 no invert", rx_data_out, 8'h5A);
        soi_valid = 1; soi_inverted = 1;
        @(negedge clk);
        soi_valid = 0; soi_inverted = 0;
        link_fail = 1;
        @(negedge clk);
        link_fail = 0; #1;
        chk("R10 linkfail clear", stat_rev_pol, 0);
        // 100M ignores pulses
        set_mode(0, 0, 0, 1, 1, 0, 0);
        soi_valid = 1; soi_inverted = 1;
        @(negedge clk);
        soi_valid = 0; soi_inverted = 0; #1;
        chk("R9 100M ignore", stat_rev_pol, 0);
        chk("R9 100M data", rx_data_out, 8'h5A);
        // 100M with flag already set: no inversion
        set_mode(0, 0, 0, 0, 0, 0, 0);
        soi_valid = 1; soi_inverted = 1;
        @(negedge clk);
        soi_valid = 0; soi_inverted = 0;
        set_mode(0, 0, 0, 1, 1, 0, 0); #1;
        chk("R9 100M no fix", rx_data_out, 8'h5A);
        soi_valid = 1;
        @(negedge clk);
        soi_valid = 0; #1;
        chk("R9 100M hold", stat_rev_pol, 1);
        rst = 1;
        @(negedge clk);
        rst = 0; #1;
        chk("R10 reset clear", stat_rev_pol, 0);

        // R12 LED0 selection (mode 100M half)
        led_sel = 2'd0;
        @(negedge clk);
        chk("R12 sel speed", led0_n, 0);
        set_mode(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R12 sel speed 10M", led0_n, 1);
        led_sel = 2'd1;
        @(negedge clk);
        chk("R12 sel link", led0_n, 0);
        link_fail = 1;
        @(negedge clk);
        chk("R12 sel link down", led0_n, 1);
        link_fail = 0; led_sel = 2'd2; tx_en = 1;
        @(negedge clk);
        chk("R12 sel crs", led0_n, 0);
        tx_en = 0; led_sel = 2'd3; collision_in = 1;
        @(negedge clk);
        chk("R12 sel col", led0_n, 0);
        collision_in = 0;
        @(negedge clk);
        chk("R12 sel col idle", led0_n, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule